// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a watchdog timer with three 16-bit registers that software reads and writes. Once software starts it, a down-counter steps on each pulse of a half-second tick input. If software does not reload the counter in time, the count runs out and the block requests a system reset. Reloading takes two writes to the service register: the arm word 0x5555 and then the fire word 0xAAAA. A stray store from runaway code is unlikely to hit that pair, so such a store cannot keep the timer alive.

Software cannot stop the timer once it has started it. The low-power suspend option is settled by the first control write after reset and cannot be changed afterwards. The block has two reset inputs. The power-on reset clears everything. The block reset clears everything except a flag recording that the last reset was caused by a timeout. That flag lets boot code tell a watchdog reset from a cold start.

Top module: `wdog_svc_timer`

## Requirements
- R1: Register offsets and read layout.
  - The control register is at byte offset 0x0 and reads as {timeout[15:8], 0000, reset-enable bit 3, enable bit 2, 0 bit 1, suspend bit 0}.
  - The status register is at 0x4. Bit 1 is the timeout-cause flag and every other bit reads 0.
  - The service register is at 0x2 and reads 0. Every other offset also reads 0.
- R2: After power-on reset, every register reads 0 and `rst_req` is low.
- R3: A service write of 0xAAAA reloads the counter with the timeout field, but only when the service write immediately before it was 0x5555.
  - Any other service write returns the tracker to idle.
  - A write of 0x5555 always arms the tracker.
- R4: Once the counter holds n, `rst_req` rises after the clock edge that samples the (n+1)th counted tick.
- R5: Writing 0 to the enable bit has no effect once it is 1.
- R6: The suspend bit takes its value from the first control write after reset, and later writes leave it unchanged. While it is 1 and `lp_mode` is high, tick pulses do not count.
- R7: The timeout-cause flag is set in the same cycle that `rst_req` rises. It survives `rst_n` and is cleared only by `por_n`.
- R8: When the reset-enable bit is 0, expiry raises `rst_req`, which stays high until a reset. When the reset-enable bit is 1, expiry raises neither `rst_req` nor the flag.
- R9: The timeout field can be rewritten while the timer is running, and the new value takes effect at the next reload. The control write that sets the enable bit loads the counter with the timeout value carried in that same write.
- R10: A reload that falls in the same cycle as an expiring tick wins, and no reset request results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; clears everything |
| rst_n | input | 1 | Block reset, active low; keeps the timeout-cause flag |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Byte offset of the register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| tick | input | 1 | Half-second count pulse, one cycle wide |
| lp_mode | input | 1 | Low-power indication |
| rst_req | output | 1 | Reset request, held until reset |

## Verification
The reload from a completed key sequence can land in the same cycle as the tick that would expire a counter already at zero. In that cycle the two functions compete for the counter. The bench forces this by issuing the fire word together with the tick pulse while the count is zero. It expects `rst_req` to stay low and the timeout period to start again in full. A random phase mixes tick pulses with service writes, so the two keep meeting, and its reference model gives the reload priority.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 3;
  localparam int TMO_W  = 8;
  localparam int TMO_LSB = 8;
  localparam int BIT_RSTEN = 3;
  localparam int BIT_EN    = 2;
  localparam int BIT_SUSP  = 0;
  localparam int BIT_TOUT  = 1;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 3'h0;
  localparam logic [ADDR_W-1:0] OFS_SVC  = 3'h2;
  localparam logic [ADDR_W-1:0] OFS_STAT = 3'h4;

  localparam logic [REG_W-1:0] KEY_ARM  = 16'h5555;
  localparam logic [REG_W-1:0] KEY_FIRE = 16'hAAAA;

  function automatic logic [REG_W-1:0] pack_ctrl(input logic [TMO_W-1:0] tmo,
                                                 input logic rsten, input logic en,
                                                 input logic susp);
    logic [REG_W-1:0] v;
    v = '0;
    v[TMO_LSB +: TMO_W] = tmo;
    v[BIT_RSTEN] = rsten;
    v[BIT_EN]    = en;
    v[BIT_SUSP]  = susp;
    return v;
  endfunction

  function automatic logic [REG_W-1:0] pack_stat(input logic tout);
    logic [REG_W-1:0] v;
    v = '0;
    v[BIT_TOUT] = tout;
    return v;
  endfunction
endpackage

// File: rtl/wdog_keyseq.sv
module wdog_keyseq
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             svc_wr,
  input  logic [REG_W-1:0] svc_data,
  output logic             reload
);
  logic armed_q;

  assign reload = svc_wr && armed_q && (svc_data == KEY_FIRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      armed_q <= 1'b0;
    else if (svc_wr) armed_q <= (svc_data == KEY_ARM);
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  input  logic         tick,
  input  logic         hold,
  output logic [W-1:0] cnt,
  output logic         expire
);
  logic step;

  assign step   = run && tick && !hold && !load;
  assign expire = step && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (load)               cnt <= load_val;
    else if (step && cnt != '0)  cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/wdog_svc_timer.sv
module wdog_svc_timer
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              tick,
  input  logic              lp_mode,
  output logic              rst_req
);
  logic             blk_rst_n;
  logic             ctrl_wr, svc_wr;
  logic [TMO_W-1:0] tmo_q;
  logic             rsten_q, en_q, susp_q, susp_lock_q;
  logic             tout_q;
  logic             en_rise, svc_reload, cnt_load, expire_evt, req_set;
  logic [TMO_W-1:0] cnt, load_val;

  assign blk_rst_n = rst_n & por_n;
  assign ctrl_wr   = reg_wr && (reg_addr == OFS_CTRL);
  assign svc_wr    = reg_wr && (reg_addr == OFS_SVC);
  assign en_rise   = ctrl_wr && reg_wdata[BIT_EN] && !en_q;
  assign cnt_load  = svc_reload || en_rise;
  assign load_val  = en_rise ? reg_wdata[TMO_LSB +: TMO_W] : tmo_q;
  assign req_set   = expire_evt && !rsten_q;

  always_ff @(posedge clk or negedge blk_rst_n) begin
    if (!blk_rst_n) begin
      tmo_q <= '0; rsten_q <= 1'b0; en_q <= 1'b0;
      susp_q <= 1'b0; susp_lock_q <= 1'b0;
    end else if (ctrl_wr) begin
      tmo_q   <= reg_wdata[TMO_LSB +: TMO_W];
      rsten_q <= reg_wdata[BIT_RSTEN];
      en_q    <= en_q | reg_wdata[BIT_EN];
      if (!susp_lock_q) begin
        susp_q      <= reg_wdata[BIT_SUSP];
        susp_lock_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge blk_rst_n) begin
    if (!blk_rst_n)   rst_req <= 1'b0;
    else if (req_set) rst_req <= 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       tout_q <= 1'b0;
    else if (req_set) tout_q <= 1'b1;
  end

  wdog_keyseq u_keyseq (
    .clk(clk), .rst_n(blk_rst_n), .svc_wr(svc_wr),
    .svc_data(reg_wdata), .reload(svc_reload)
  );

  wdog_counter #(.W(TMO_W)) u_counter (
    .clk(clk), .rst_n(blk_rst_n), .load(cnt_load), .load_val(load_val),
    .run(en_q && !rst_req), .tick(tick), .hold(susp_q && lp_mode),
    .cnt(cnt), .expire(expire_evt)
  );

  always_comb begin
    unique case (reg_addr)
      OFS_CTRL: reg_rdata = pack_ctrl(tmo_q, rsten_q, en_q, susp_q);
      OFS_STAT: reg_rdata = pack_stat(tout_q);
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdog_svc_timer_chk.sv
module wdog_svc_timer_chk
  import wdog_pkg::*;
(
  input logic             clk,
  input logic             por_n,
  input logic             rst_n,
  input logic             en_q,
  input logic             susp_q,
  input logic             lp_mode,
  input logic             svc_reload,
  input logic             expire_evt,
  input logic [TMO_W-1:0] cnt,
  input logic [TMO_W-1:0] tmo_q,
  input logic             rst_req,
  input logic             tout_q
);
  AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    en_q |=> en_q); // R5
  AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    svc_reload |=> cnt == $past(tmo_q)); // R3
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    rst_req |=> rst_req); // R8
  AST_REQ_FLAG: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    rst_req |-> tout_q); // R7
  AST_SUSP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (susp_q && lp_mode && !svc_reload) |=> $stable(cnt)); // R6
  AST_NO_REQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    !en_q |-> !rst_req); // R8
  AST_RELOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    svc_reload |-> !expire_evt); // R10
endmodule

bind wdog_svc_timer wdog_svc_timer_chk u_chk (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .en_q(en_q), .susp_q(susp_q),
  .lp_mode(lp_mode), .svc_reload(svc_reload), .expire_evt(expire_evt),
  .cnt(cnt), .tmo_q(tmo_q), .rst_req(rst_req), .tout_q(tout_q)
);

// File: tb/wdog_svc_timer_tb_top.sv
module wdog_svc_timer_tb_top;
  logic        clk = 1'b0;
  logic        por_n = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 1'b0, tick = 1'b0, lp_mode = 1'b0;
  logic [2:0]  reg_addr = 3'h0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic        rst_req;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  wdog_svc_timer dut_i (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick(tick), .lp_mode(lp_mode),
    .rst_req(rst_req)
  );

  // reference state, kept from the requirements
  logic [7:0] m_tmo, m_cnt;
  logic       m_rsten, m_en, m_susp, m_lock, m_armed, m_req, m_flag;

  function automatic logic [15:0] exp_read(input logic [2:0] a);
    if (a == 3'h0) return {m_tmo, 4'b0, m_rsten, m_en, 1'b0, m_susp};
    if (a == 3'h4) return {14'b0, m_flag, 1'b0};
    return 16'h0;
  endfunction

  task automatic clear_blk();
    m_tmo = 0; m_cnt = 0; m_rsten = 0; m_en = 0; m_susp = 0; m_lock = 0;
    m_armed = 0; m_req = 0;
  endtask

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input bit w, input logic [2:0] a, input logic [15:0] d,
                      input bit t, input bit l, input string tag);
    bit reload, expire, counting;
    @(negedge clk);
    reg_wr = w; reg_addr = a; reg_wdata = d; tick = t; lp_mode = l;
    reload   = w && a == 3'h2 && d == 16'hAAAA && m_armed;
    counting = m_en && !m_req && t && !(m_susp && l) && !reload;
    expire   = counting && m_cnt == 0;
    @(posedge clk);
    #1;
    if (w && a == 3'h2) m_armed = (d == 16'h5555);
    if (reload) m_cnt = m_tmo;
    else if (counting && m_cnt != 0) m_cnt = m_cnt - 1;
    if (expire && !m_rsten) begin m_req = 1; m_flag = 1; end
    if (w && a == 3'h0) begin
      if (!m_en && d[2]) m_cnt = d[15:8];
      m_tmo = d[15:8]; m_rsten = d[3]; m_en = m_en | d[2];
      if (!m_lock) begin m_susp = d[0]; m_lock = 1; end
    end
    check(tag, {15'b0, rst_req}, {15'b0, m_req});
    check(tag, reg_rdata, exp_read(a));
  endtask

  task automatic idle(input int n, input bit t, input bit l, input string tag);
    for (int i = 0; i < n; i++) step(0, 3'h0, 16'h0, t, l, tag);
  endtask

  task automatic do_por();
    @(negedge clk); por_n = 0; rst_n = 0; reg_wr = 0; tick = 0;
    clear_blk(); m_flag = 0;
    @(negedge clk); por_n = 1; rst_n = 1;
  endtask

  task automatic do_blk_rst();
    @(negedge clk); rst_n = 0; reg_wr = 0; tick = 0;
    clear_blk();
    @(negedge clk); rst_n = 1;
  endtask

  initial begin
    void'($urandom(32'h5eed));
    clear_blk(); m_flag = 0;
    repeat (2) @(posedge clk);
    do_por();
    step(0, 3'h0, 0, 0, 0, "R2"); step(0, 3'h4, 0, 0, 0, "R2"); step(0, 3'h2, 0, 0, 0, "R1");
    // enable with timeout 3 and suspend, then try to clear both
    step(1, 3'h0, 16'h0305, 0, 0, "R9");
    step(1, 3'h0, 16'h0700, 0, 0, "R5");
    step(0, 3'h0, 0, 0, 0, "R6");
    idle(3, 1, 0, "R4");
    step(0, 3'h0, 0, 1, 0, "R4");
    step(0, 3'h4, 0, 0, 0, "R7");
    do_blk_rst();
    step(0, 3'h4, 0, 0, 0, "R7");
    do_por();
    step(0, 3'h4, 0, 0, 0, "R7");
    // suspend locked by first write, then enable with timeout 1
    step(1, 3'h0, 16'h0001, 0, 0, "R6");
    step(1, 3'h0, 16'h0104, 0, 0, "R6");
    idle(5, 1, 1, "R6");
    idle(1, 1, 0, "R6");
    // key sequence variants (count now 0)
    step(1, 3'h2, 16'h5555, 0, 0, "R3");
    step(1, 3'h2, 16'hAAAA, 0, 0, "R3");
    step(1, 3'h0, 16'h0604, 0, 0, "R9");
    idle(1, 1, 0, "R9");
    step(1, 3'h2, 16'hAAAA, 0, 0, "R3");
    step(1, 3'h2, 16'h5555, 0, 0, "R3");
    step(1, 3'h2, 16'h1234, 0, 0, "R3");
    step(1, 3'h2, 16'hAAAA, 0, 0, "R3");
    step(1, 3'h2, 16'h5555, 0, 0, "R3");
    step(1, 3'h2, 16'h5555, 0, 0, "R3");
    step(1, 3'h2, 16'hAAAA, 0, 0, "R3");
    idle(6, 1, 0, "R9");
    // reload and expiring tick in the same cycle
    step(1, 3'h2, 16'h5555, 0, 0, "R10");
    step(1, 3'h2, 16'hAAAA, 1, 0, "R10");
    idle(8, 1, 0, "R10");
    // reset-enable set: expiry makes no request
    do_por();
    step(1, 3'h0, 16'h000C, 0, 0, "R8");
    idle(4, 1, 0, "R8");
    step(0, 3'h4, 0, 0, 0, "R8");
    step(0, 3'h1, 0, 0, 0, "R1");
    // random phase
    do_por();
    step(1, 3'h0, 16'h0205, 0, 0, "R9");
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [15:0] d;
      r = $urandom_range(0, 99);
      d = (r < 20) ? 16'h5555 : (r < 40) ? 16'hAAAA : 16'($urandom);
      if (m_req && $urandom_range(0, 3) == 0) begin
        do_blk_rst();
        step(0, 3'h4, 0, 0, 0, "R7");
        step(1, 3'h0, {8'($urandom_range(0, 4)), 8'h05}, 0, 0, "R9");
      end else if (r < 50) step(1, 3'h2, d, $urandom_range(0, 2) == 0, $urandom_range(0, 4) == 0, "R3");
      else step(0, (r < 60) ? 3'h4 : 3'h0, 0, $urandom_range(0, 2) == 0,
                $urandom_range(0, 4) == 0, "R4");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule